// File: doc/BRIEF.md
# Warp Formation and Lane Mask Tracker

This block divides a thread group of any size into warps of 32 lanes. It keeps one lane-enable mask per warp. When a group is launched with a thread count, threads are placed in ascending order: thread n sits in warp n/32, lane n%32. Lanes of the last warp that have no thread behind them start disabled. The number of warps is reported, and it stops growing at the number of warp slots the block has.

After launch, a scheduler issues commands to one selected warp at a time:

- A branch with a per-lane predicate.
- A reconverge strobe.
- A retire strobe with a lane mask.

A branch on which the enabled lanes disagree runs the taken lanes first. The two masks needed later are saved on a small per-warp stack. Successive reconverge strobes then switch to the lanes that did not take the branch, and after that restore the mask held before the branch. Retired lanes are removed from the live mask and from every saved mask, so they never come back. A warp signals done one cycle after nothing is left in it.

Top module: `wf_warp_unit`

## Requirements
- R1: One cycle after launch, the warp count output equals ceil(thread_count/32), capped at MAX_WARPS.
- R2: One cycle after launch, lane l of warp w is enabled exactly when w*32+l is below the thread count. Warps at or beyond the warp count have an all-zero mask.
- R3: A group of one thread gives a warp count of 1 and a warp 0 mask of 0x0000_0001. A count that is not a multiple of 32 leaves only the low count%32 lanes of the last warp enabled.
- R4: A branch whose predicate splits the enabled lanes sets the warp mask to enabled&pred on the next cycle and saves one stack entry.
- R5: A branch on which all enabled lanes agree (enabled&pred or enabled&~pred is zero) leaves the mask unchanged and saves nothing. Predicate bits of disabled lanes have no effect.
- R6: Reconverge acts on the newest saved entry. If the entry still holds the not-taken lanes, the mask switches to them. Otherwise the saved pre-branch mask is restored and the entry is dropped. Reconverge with no saved entry changes nothing. Nested branches unwind newest first.
- R7: Each warp saves at most DEPTH (default 4) entries. A divergent branch when the stack is full leaves the mask unchanged and sets stack_ovf_o. The flag stays set until the next launch.
- R8: Retire clears the given lanes from the warp mask and from all of its saved masks, so a later reconverge cannot re-enable them.
- R9: warp_done_o[w] rises one cycle after a launched warp's mask and all of its saved masks are zero. It stays low while a saved path still holds live lanes.
- R10: Launch clears every stack, every done flag and stack_ovf_o.
- R11: Commands act only on the warp selected by warp_sel_i. When strobes coincide, only the highest one in the order launch, branch, reconverge, retire takes effect.
- R12: After reset the warp count, all masks, all done flags and stack_ovf_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start a new group with thread_cnt_i threads |
| thread_cnt_i | input | CNT_W | Thread count of the group |
| warp_sel_i | input | WID_W | Warp that branch, reconverge and retire act on |
| branch_i | input | 1 | Branch strobe |
| pred_i | input | 32 | Per-lane branch predicate, bit l for lane l |
| reconv_i | input | 1 | Reconverge strobe |
| retire_i | input | 1 | Retire strobe |
| retire_mask_i | input | 32 | Lanes that retire |
| warp_cnt_o | output | WCNT_W | Number of warps in the group |
| active_masks_o | output | MAX_WARPS*32 | Lane masks, warp w at bits w*32 +: 32 |
| warp_done_o | output | MAX_WARPS | Per-warp done flag |
| stack_ovf_o | output | 1 | Stack overflow, sticky until launch |

## Verification
Every thread count from 0 past the saturation point of a four-warp build is launched, and each warp mask is compared with an arithmetic expectation. This separates a correct ceiling and cap from off-by-one errors at multiples of 32, and it shows partial warps apart from full ones. Branch patterns are chosen to cover distinct cases:

- a split on a full warp;
- a predicate that only disagrees on disabled lanes;
- a five-deep nest that overflows.

Together these separate divergence from uniformity and show that unwinding is newest first. Retirement is tried on a warp that is not divergent and on a divergent warp whose taken path empties while the other path is pending. This tells an early done apart from a correct one. Coinciding strobes and commands to a neighbouring warp confirm priority and selection.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned WF_LANES = 32;
  localparam int unsigned WF_LOG_LANES = $clog2(WF_LANES);

  typedef logic [WF_LANES-1:0] lane_mask_t;

  typedef struct packed {
    lane_mask_t other;    // lanes still waiting for the second path
    lane_mask_t restore;  // mask to reinstate at reconvergence
  } div_entry_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_BRANCH = 2'd1,
    OP_RECONV = 2'd2,
    OP_RETIRE = 2'd3
  } warp_op_t;

  // lanes of a warp whose first thread id is base, given cnt threads
  function automatic lane_mask_t first_lanes(input int unsigned base, input int unsigned cnt);
    lane_mask_t m;
    for (int unsigned l = 0; l < WF_LANES; l++) m[l] = (base + l) < cnt;
    return m;
  endfunction
endpackage

// File: rtl/wf_warp_count.sv
module wf_warp_count
  import wf_pkg::*;
#(
  parameter int unsigned MAX_WARPS = 32,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned WCNT_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WCNT_W-1:0] warp_cnt_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0]  rounded;
  logic [SUM_W-1:0]  quot;
  logic [WCNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    rounded = {1'b0, cnt_i} + SUM_W'(WF_LANES - 1);
    quot    = rounded >> WF_LOG_LANES;
    if (quot > SUM_W'(MAX_WARPS)) cnt_d = WCNT_W'(MAX_WARPS);
    else                          cnt_d = WCNT_W'(quot);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (launch_i) cnt_q <= cnt_d;
  end

  assign warp_cnt_o = cnt_q;
endmodule

// File: rtl/wf_warp_ctx.sv
module wf_warp_ctx
  import wf_pkg::*;
#(
  parameter int unsigned IDX   = 0,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  warp_op_t         op_i,
  input  lane_mask_t       pred_i,
  input  lane_mask_t       retire_mask_i,
  output lane_mask_t       active_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);
  localparam int unsigned BASE = IDX * WF_LANES;

  div_entry_t       stk_q [DEPTH];
  div_entry_t       stk_d [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d;
  lane_mask_t       act_q, act_d;
  logic             live_q, live_d;
  logic             done_q, done_d;
  logic             ovf_q, ovf_d;

  lane_mask_t taken, not_taken, pend;
  div_entry_t top;
  logic       full, empty, split;

  assign taken     = act_q & pred_i;
  assign not_taken = act_q & ~pred_i;
  assign split     = (taken != '0) && (not_taken != '0);
  assign full      = (sp_q == SP_W'(DEPTH));
  assign empty     = (sp_q == '0);

  always_comb begin
    top  = '0;
    pend = '0;
    for (int unsigned e = 0; e < DEPTH; e++) begin
      if (SP_W'(e + 1) == sp_q) top = stk_q[e];
      if (SP_W'(e) < sp_q)      pend = pend | stk_q[e].other | stk_q[e].restore;
    end
  end

  always_comb begin
    stk_d  = stk_q;
    sp_d   = sp_q;
    act_d  = act_q;
    live_d = live_q;
    ovf_d  = ovf_q;
    if (launch_i) begin
      act_d  = first_lanes(BASE, 32'(cnt_i));
      live_d = 32'(cnt_i) > BASE;
      sp_d   = '0;
      ovf_d  = 1'b0;
      for (int unsigned e = 0; e < DEPTH; e++) stk_d[e] = '0;
    end else begin
      unique case (op_i)
        OP_BRANCH: begin
          if (split) begin
            if (full) begin
              ovf_d = 1'b1;
            end else begin
              for (int unsigned e = 0; e < DEPTH; e++) begin
                if (SP_W'(e) == sp_q) begin
                  stk_d[e].other   = not_taken;
                  stk_d[e].restore = act_q;
                end
              end
              sp_d  = sp_q + SP_W'(1);
              act_d = taken;
            end
          end
        end
        OP_RECONV: begin
          if (!empty) begin
            if (top.other != '0) begin
              act_d = top.other;
              for (int unsigned e = 0; e < DEPTH; e++)
                if (SP_W'(e + 1) == sp_q) stk_d[e].other = '0;
            end else begin
              act_d = top.restore;
              sp_d  = sp_q - SP_W'(1);
            end
          end
        end
        OP_RETIRE: begin
          act_d = act_q & ~retire_mask_i;
          for (int unsigned e = 0; e < DEPTH; e++) begin
            stk_d[e].other   = stk_q[e].other & ~retire_mask_i;
            stk_d[e].restore = stk_q[e].restore & ~retire_mask_i;
          end
        end
        default: ;
      endcase
    end
  end

  // done follows one cycle behind the state that empties the warp
  assign done_d = !launch_i && live_q && (act_q == '0) && (pend == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned e = 0; e < DEPTH; e++) stk_q[e] <= '0;
      sp_q   <= '0;
      act_q  <= '0;
      live_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      stk_q  <= stk_d;
      sp_q   <= sp_d;
      act_q  <= act_d;
      live_q <= live_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign active_o = act_q;
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/wf_warp_unit.sv
module wf_warp_unit
  import wf_pkg::*;
#(
  parameter int unsigned MAX_WARPS = 32,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned CNT_W     = $clog2(MAX_WARPS * WF_LANES + 1),
  parameter int unsigned WID_W     = (MAX_WARPS > 1) ? $clog2(MAX_WARPS) : 1,
  parameter int unsigned WCNT_W    = $clog2(MAX_WARPS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          launch_i,
  input  logic [CNT_W-1:0]              thread_cnt_i,
  input  logic [WID_W-1:0]              warp_sel_i,
  input  logic                          branch_i,
  input  logic [WF_LANES-1:0]           pred_i,
  input  logic                          reconv_i,
  input  logic                          retire_i,
  input  logic [WF_LANES-1:0]           retire_mask_i,
  output logic [WCNT_W-1:0]             warp_cnt_o,
  output logic [MAX_WARPS*WF_LANES-1:0] active_masks_o,
  output logic [MAX_WARPS-1:0]          warp_done_o,
  output logic                          stack_ovf_o
);
  warp_op_t             op;
  logic [MAX_WARPS-1:0] ovf_vec;

  // launch outranks every per-warp command; it is applied inside each context
  always_comb begin
    if (branch_i)      op = OP_BRANCH;
    else if (reconv_i) op = OP_RECONV;
    else if (retire_i) op = OP_RETIRE;
    else               op = OP_NONE;
  end

  wf_warp_count #(
    .MAX_WARPS (MAX_WARPS),
    .CNT_W     (CNT_W),
    .WCNT_W    (WCNT_W)
  ) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch_i),
    .cnt_i      (thread_cnt_i),
    .warp_cnt_o (warp_cnt_o)
  );

  for (genvar w = 0; w < MAX_WARPS; w++) begin : g_warp
    warp_op_t   op_w;
    lane_mask_t act_w;

    assign op_w = (warp_sel_i == WID_W'(w)) ? op : OP_NONE;

    wf_warp_ctx #(
      .IDX   (w),
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
    ) u_ctx (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .launch_i      (launch_i),
      .cnt_i         (thread_cnt_i),
      .op_i          (op_w),
      .pred_i        (pred_i),
      .retire_mask_i (retire_mask_i),
      .active_o      (act_w),
      .done_o        (warp_done_o[w]),
      .ovf_o         (ovf_vec[w])
    );

    assign active_masks_o[w*WF_LANES +: WF_LANES] = act_w;
  end

  assign stack_ovf_o = |ovf_vec;
endmodule

// File: rtl/wf_warp_unit_chk.sv
module wf_warp_unit_chk
  import wf_pkg::*;
#(
  parameter int unsigned MAX_WARPS = 32,
  parameter int unsigned WID_W     = 5,
  parameter int unsigned WCNT_W    = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          launch_i,
  input logic [WID_W-1:0]              warp_sel_i,
  input logic                          branch_i,
  input logic [WF_LANES-1:0]           pred_i,
  input logic                          reconv_i,
  input logic                          retire_i,
  input logic [WF_LANES-1:0]           retire_mask_i,
  input logic [WCNT_W-1:0]             warp_cnt_o,
  input logic [MAX_WARPS*WF_LANES-1:0] active_masks_o,
  input logic [MAX_WARPS-1:0]          warp_done_o,
  input logic                          stack_ovf_o
);
  logic [WID_W-1:0] sel_q;
  lane_mask_t       cur_sel, nxt_sel;
  logic             sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= warp_sel_i;
  end

  always_comb begin
    cur_sel = '0;
    nxt_sel = '0;
    for (int unsigned w = 0; w < MAX_WARPS; w++) begin
      if (warp_sel_i == WID_W'(w)) cur_sel = active_masks_o[w*WF_LANES +: WF_LANES];
      if (sel_q == WID_W'(w))      nxt_sel = active_masks_o[w*WF_LANES +: WF_LANES];
    end
  end

  assign sel_ok = 32'(warp_sel_i) < MAX_WARPS;

  // R1
  warp_cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warp_cnt_o <= WCNT_W'(MAX_WARPS));

  // R4
  div_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && branch_i && sel_ok && ((cur_sel & pred_i) != '0) && ((cur_sel & ~pred_i) != '0))
    |=> (nxt_sel == ($past(cur_sel) & $past(pred_i))) || (stack_ovf_o && nxt_sel == $past(cur_sel)));

  // R5
  uniform_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && branch_i && sel_ok && (((cur_sel & pred_i) == '0) || ((cur_sel & ~pred_i) == '0)))
    |=> nxt_sel == $past(cur_sel));

  // R8
  retire_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && !branch_i && !reconv_i && retire_i && sel_ok)
    |=> (nxt_sel & $past(retire_mask_i)) == '0);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_ovf_o && !launch_i) |=> stack_ovf_o);

  // R10
  launch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (!stack_ovf_o && warp_done_o == '0));

  for (genvar w = 0; w < MAX_WARPS; w++) begin : g_w
    // R9
    done_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warp_done_o[w] |-> active_masks_o[w*WF_LANES +: WF_LANES] == '0);

    // R2
    idle_warp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(warp_cnt_o) <= w) |-> active_masks_o[w*WF_LANES +: WF_LANES] == '0);
  end
endmodule

bind wf_warp_unit wf_warp_unit_chk #(
  .MAX_WARPS (MAX_WARPS),
  .WID_W     (WID_W),
  .WCNT_W    (WCNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .launch_i       (launch_i),
  .warp_sel_i     (warp_sel_i),
  .branch_i       (branch_i),
  .pred_i         (pred_i),
  .reconv_i       (reconv_i),
  .retire_i       (retire_i),
  .retire_mask_i  (retire_mask_i),
  .warp_cnt_o     (warp_cnt_o),
  .active_masks_o (active_masks_o),
  .warp_done_o    (warp_done_o),
  .stack_ovf_o    (stack_ovf_o)
);

// File: tb/wf_warp_unit_test.sv
`timescale 1ns/1ps
module wf_warp_unit_test;
  localparam int MW     = 4;
  localparam int CNT_W  = $clog2(MW * 32 + 1);
  localparam int WID_W  = $clog2(MW);
  localparam int WCNT_W = $clog2(MW + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              launch = 1'b0;
  logic [CNT_W-1:0]  cnt = '0;
  logic [WID_W-1:0]  sel = '0;
  logic              branch = 1'b0;
  logic [31:0]       pred = '0;
  logic              reconv = 1'b0;
  logic              retire = 1'b0;
  logic [31:0]       rmask = '0;
  logic [WCNT_W-1:0] wcnt;
  logic [MW*32-1:0]  masks;
  logic [MW-1:0]     done;
  logic              ovf;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wf_warp_unit #(.MAX_WARPS(MW), .DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .thread_cnt_i(cnt),
    .warp_sel_i(sel), .branch_i(branch), .pred_i(pred), .reconv_i(reconv),
    .retire_i(retire), .retire_mask_i(rmask), .warp_cnt_o(wcnt),
    .active_masks_o(masks), .warp_done_o(done), .stack_ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int w);
    return masks[w*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_mask(input int c, input int w);
    if (w >= MW)          return 32'h0;
    if (c >= (w + 1) * 32) return 32'hFFFF_FFFF;
    if (c <= w * 32)       return 32'h0;
    return (32'h1 << (c - w * 32)) - 32'h1;
  endfunction

  task automatic do_launch(input int c);
    cnt = CNT_W'(c); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask
  task automatic do_branch(input int w, input logic [31:0] p);
    sel = WID_W'(w); pred = p; branch = 1'b1;
    @(negedge clk); branch = 1'b0;
  endtask
  task automatic do_reconv(input int w);
    sel = WID_W'(w); reconv = 1'b1;
    @(negedge clk); reconv = 1'b0;
  endtask
  task automatic do_retire(input int w, input logic [31:0] m);
    sel = WID_W'(w); rmask = m; retire = 1'b1;
    @(negedge clk); retire = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] unwind [9];
    unwind = '{32'h0000_000C, 32'h0000_000F, 32'h0000_00F0, 32'h0000_00FF,
               32'h0000_FF00, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF,
               32'hFFFF_FFFF};
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12 count", 128'(wcnt), 0);
    chk("R12 masks", masks, 0);
    chk("R12 done/ovf", 128'({done, ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: sweep every count through saturation
    for (int c = 0; c <= 200; c++) begin
      int ew;
      do_launch(c);
      ew = (c == 0) ? 0 : (((c - 1) / 32 + 1) > MW ? MW : (c - 1) / 32 + 1);
      chk("R1 warp count", 128'(wcnt), 128'(ew));
      for (int w = 0; w < MW; w++) chk("R2 lane map", 128'(mk(w)), 128'(exp_mask(c, w)));
    end
    do_launch(1);
    chk("R3 single thread count", 128'(wcnt), 1);
    chk("R3 single thread mask", 128'(mk(0)), 1);

    // R4 R6 divergence on warp 1
    do_launch(100);
    chk("R3 partial last warp", 128'(mk(3)), 128'h0000_000F);
    do_branch(1, 32'h0000_FFFF);
    chk("R4 taken path", 128'(mk(1)), 128'h0000_FFFF);
    chk("R11 other warp untouched", 128'(mk(2)), 128'hFFFF_FFFF);
    do_reconv(1);
    chk("R6 other path", 128'(mk(1)), 128'hFFFF_0000);
    do_reconv(1);
    chk("R6 restore", 128'(mk(1)), 128'hFFFF_FFFF);
    do_reconv(1);
    chk("R6 empty reconv", 128'(mk(1)), 128'hFFFF_FFFF);

    // R5 uniform: disagreement only on disabled lanes
    do_branch(3, 32'hFFFF_FFF0);
    chk("R5 uniform branch", 128'(mk(3)), 128'h0000_000F);
    do_reconv(3);
    chk("R5 nothing pushed", 128'(mk(3)), 128'h0000_000F);

    // R7 nest to depth 4 then overflow on warp 0
    do_branch(0, 32'h0000_FFFF);
    do_branch(0, 32'h0000_00FF);
    do_branch(0, 32'h0000_000F);
    do_branch(0, 32'h0000_0003);
    chk("R4 nested depth 4", 128'(mk(0)), 128'h3);
    chk("R7 no ovf at depth", 128'(ovf), 0);
    do_branch(0, 32'h0000_0001);
    chk("R7 ovf flag", 128'(ovf), 1);
    chk("R7 mask held", 128'(mk(0)), 128'h3);
    for (int i = 0; i < 9; i++) begin
      do_reconv(0);
      chk("R6 unwind order", 128'(mk(0)), 128'(unwind[i]));
    end

    // R8 R9 retire on warp 3
    do_retire(3, 32'h0000_0003);
    chk("R8 partial retire", 128'(mk(3)), 128'h0000_000C);
    chk("R9 not done", 128'(done[3]), 0);
    do_retire(3, 32'h0000_000C);
    chk("R8 all retired", 128'(mk(3)), 0);
    chk("R9 done lags", 128'(done[3]), 0);
    @(negedge clk);
    chk("R9 done", 128'(done[3]), 1);

    // R8 R9 retire while divergent on warp 2
    do_branch(2, 32'h0000_00FF);
    do_retire(2, 32'h0000_00FF);
    chk("R8 taken path emptied", 128'(mk(2)), 0);
    @(negedge clk); @(negedge clk);
    chk("R9 pending path keeps warp", 128'(done[2]), 0);
    do_reconv(2);
    chk("R6 switch after retire", 128'(mk(2)), 128'hFFFF_FF00);
    do_retire(2, 32'hFFFF_FF00);
    @(negedge clk);
    chk("R9 done after both paths", 128'(done[2]), 1);
    do_reconv(2);
    chk("R8 retired lanes not restored", 128'(mk(2)), 0);
    chk("R7 ovf sticky", 128'(ovf), 1);

    // R10 launch clears flags, R11 priority
    do_launch(64);
    chk("R10 ovf cleared", 128'(ovf), 0);
    chk("R10 done cleared", 128'(done), 0);
    sel = 2'd1; pred = 32'h0000_00FF; rmask = 32'h0000_000F;
    branch = 1'b1; retire = 1'b1;
    @(negedge clk); branch = 1'b0; retire = 1'b0;
    chk("R11 branch over retire", 128'(mk(1)), 128'h0000_00FF);
    sel = 2'd1; pred = 32'h0000_000F; reconv = 1'b1; launch = 1'b1; cnt = CNT_W'(40);
    @(negedge clk); reconv = 1'b0; launch = 1'b0;
    chk("R11 launch over reconv", 128'(mk(1)), 128'h0000_00FF);
    chk("R11 launch count", 128'(wcnt), 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule